// File: doc/BRIEF.md
# Circulating Cell-Select Register Bank

This block models the serial control side of a switched-capacitor sampling array. Three registers sit behind a 4-bit select bus and share one serial clock and one serial data line. There is an 8-bit configuration word, an 8-bit write-control word and a 1024-stage selection ring. The ring holds a single "1" that marks the sampling cell being read. Each clock moves the marker one stage. When the marker leaves the final stage it re-enters at cell 0, so the same position comes back every 1024 clocks.

The ring takes serial data only while its own select code is on the bus. In that state the serial bit is written into the final stage, and the rest of the ring keeps advancing. Clocking in 1023 zeros and then a single one therefore clears whatever the ring held and leaves the marker in the final stage. The next clock places it in cell 0. The reset line returns both 8-bit words to all ones but never touches the ring. The ring has no defined content until that load sequence has been run. The ring's final stage and the encoded marker position are brought out to the ports so that the cell currently selected can be observed.

Top module: `cell_ring_bank`

## Requirements
- R1: While rst_n is low at a rising clk edge, cfg_word and wsr_word become all ones (8'hFF) after that edge.
- R2: With addr == 4'hB at a rising edge, ring_tail (stage 1023) takes the value sdin had at that edge.
- R3: Clocking 1023 zeros and then one "1" with addr == 4'hB leaves exactly one set stage, at cell 1023 (cell_idx == 1023, ring_tail == 1). This holds whatever the ring held before.
- R4: With addr != 4'hB, a marker at cell k moves to cell k+1 at each rising edge, and from cell 1023 it moves to cell 0. After 1024 such edges it is back at its starting cell.
- R5: cell_idx gives the index of the set stage. cell_hit is 1 while any stage is set. ring_tail is 1 exactly when the marker is at cell 1023.
- R6: rst_n has no effect on the ring: the marker keeps advancing one cell per edge while reset is held low.
- R7: With addr == 4'hC and rst_n high, cfg_word shifts left by one each edge and sdin enters bit 0. A byte therefore loads MSB first in 8 edges.
- R8: With addr == 4'hD and rst_n high, wsr_word loads in the same MSB-first way.
- R9: Any select code other than 4'hC or 4'hD leaves cfg_word and wsr_word unchanged. Codes other than 4'hB also leave the ring recirculating, whatever sdin carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all registers act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the two 8-bit words |
| addr | input | 4 | Register select code |
| sdin | input | 1 | Serial data input |
| ring_tail | output | 1 | Final stage (cell 1023) of the selection ring |
| cell_idx | output | 10 | Index of the set stage in the ring |
| cell_hit | output | 1 | High while any ring stage is set |
| cfg_word | output | 8 | Configuration word |
| wsr_word | output | 8 | Write-control word |

## Verification
The ring checks assume that the ring never holds more than one set stage. If it did, the marker index would have no meaning. The stimulus ensures this by loading the ring only with runs of zeros closed by a single one. It also shifts the ring only through the full 1024-clock load or through plain recirculation. The ring is never examined before its first complete load. The select bus and serial data change only on falling edges, so every register sees stable inputs at the rising edge.

// File: rtl/cell_ring_pkg.sv
package cell_ring_pkg;

   typedef enum logic [1:0] {
      SEL_IDLE = 2'd0,
      SEL_CFG  = 2'd1,
      SEL_WSR  = 2'd2,
      SEL_RING = 2'd3
   } bank_sel_e;

   localparam logic [3:0] DEF_CODE_RING = 4'hB;
   localparam logic [3:0] DEF_CODE_CFG  = 4'hC;
   localparam logic [3:0] DEF_CODE_WSR  = 4'hD;

endpackage

// File: rtl/serial_field.sv
module serial_field #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         sdin,
   output logic [W-1:0] q
);
   generate
      if (W < 2) begin : g_bad_width
         $error("serial_field: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '1;
      else if (shift_en)
         q <= {q[W-2:0], sdin};
   end
endmodule

// File: rtl/cell_ring.sv
module cell_ring #(
   parameter int CELLS = 1024
) (
   input  logic             clk,
   input  logic             load_en,
   input  logic             sdin,
   output logic [CELLS-1:0] stages
);
   localparam int LAST = CELLS - 1;

   generate
      if (CELLS < 3) begin : g_bad_depth
         $error("cell_ring: CELLS must be at least 3");
      end
   endgenerate

   logic [CELLS-1:0] nxt;

   // The head always takes the old tail. The tail takes serial data while loading.
   generate
      for (genvar i = 0; i < CELLS; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign nxt[i] = stages[LAST];
         end else if (i == LAST) begin : g_tail
            assign nxt[i] = load_en ? sdin : stages[i-1];
         end else begin : g_mid
            assign nxt[i] = stages[i-1];
         end
      end
   endgenerate

   // No reset: the ring keeps its content across rst_n.
   always_ff @(posedge clk) begin
      stages <= nxt;
   end
endmodule

// File: rtl/onehot_locator.sv
module onehot_locator #(
   parameter int N        = 1024,
   parameter bit PRIORITY = 1'b0,
   localparam int IDX_W   = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             hit
);
   assign hit = |vec;

   generate
      if (PRIORITY) begin : g_prio
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (vec[i]) idx = IDX_W'(i);
            end
         end
      end else begin : g_orfold
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (vec[i]) idx = idx | IDX_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cell_ring_bank.sv
module cell_ring_bank
   import cell_ring_pkg::*;
#(
   parameter int          CELLS     = 1024,
   parameter int          CFG_W     = 8,
   parameter int          WSR_W     = 8,
   parameter int          ADDR_W    = 4,
   parameter logic [3:0]  CODE_RING = DEF_CODE_RING,
   parameter logic [3:0]  CODE_CFG  = DEF_CODE_CFG,
   parameter logic [3:0]  CODE_WSR  = DEF_CODE_WSR,
   parameter bit          PRIO_ENC  = 1'b0,
   localparam int         IDX_W     = $clog2(CELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sdin,
   output logic              ring_tail,
   output logic [IDX_W-1:0]  cell_idx,
   output logic              cell_hit,
   output logic [CFG_W-1:0]  cfg_word,
   output logic [WSR_W-1:0]  wsr_word
);
   generate
      if (ADDR_W != 4) begin : g_bad_addr
         $error("cell_ring_bank: ADDR_W must be 4");
      end
      if (CODE_RING == CODE_CFG || CODE_RING == CODE_WSR || CODE_CFG == CODE_WSR) begin : g_bad_codes
         $error("cell_ring_bank: select codes must be distinct");
      end
      if ((1 << IDX_W) < CELLS) begin : g_bad_idx
         $error("cell_ring_bank: index width too small");
      end
   endgenerate

   bank_sel_e sel;

   always_comb begin
      if (addr == CODE_RING)     sel = SEL_RING;
      else if (addr == CODE_CFG) sel = SEL_CFG;
      else if (addr == CODE_WSR) sel = SEL_WSR;
      else                       sel = SEL_IDLE;
   end

   logic [CELLS-1:0] stages;

   serial_field #(.W(CFG_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sel == SEL_CFG),
      .sdin     (sdin),
      .q        (cfg_word)
   );

   serial_field #(.W(WSR_W)) u_wsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sel == SEL_WSR),
      .sdin     (sdin),
      .q        (wsr_word)
   );

   cell_ring #(.CELLS(CELLS)) u_ring (
      .clk     (clk),
      .load_en (sel == SEL_RING),
      .sdin    (sdin),
      .stages  (stages)
   );

   onehot_locator #(.N(CELLS), .PRIORITY(PRIO_ENC)) u_loc (
      .vec (stages),
      .idx (cell_idx),
      .hit (cell_hit)
   );

   assign ring_tail = stages[CELLS-1];
endmodule

// File: rtl/cell_ring_bank_chk.sv
module cell_ring_bank_chk #(
   parameter int          CELLS     = 1024,
   parameter int          CFG_W     = 8,
   parameter int          WSR_W     = 8,
   parameter int          ADDR_W    = 4,
   parameter logic [3:0]  CODE_RING = 4'hB,
   parameter logic [3:0]  CODE_CFG  = 4'hC,
   parameter logic [3:0]  CODE_WSR  = 4'hD,
   parameter bit          PRIO_ENC  = 1'b0,
   localparam int         IDX_W     = $clog2(CELLS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              sdin,
   input logic              ring_tail,
   input logic [IDX_W-1:0]  cell_idx,
   input logic              cell_hit,
   input logic [CFG_W-1:0]  cfg_word,
   input logic [WSR_W-1:0]  wsr_word
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELLS - 1);

   // R2
   ring_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(addr) == CODE_RING |-> ring_tail == $past(sdin));

   // R4
   ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != CODE_RING && cell_hit) |=>
         (cell_hit && cell_idx == (($past(cell_idx) == LAST_IDX) ? '0 : $past(cell_idx) + 1'b1)));

   // R5
   tail_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cell_hit |-> ring_tail == (cell_idx == LAST_IDX));

   // R7
   cfg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(addr) == CODE_CFG) |->
         cfg_word == {$past(cfg_word[CFG_W-2:0]), $past(sdin)});

   // R8
   wsr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(addr) == CODE_WSR) |->
         wsr_word == {$past(wsr_word[WSR_W-2:0]), $past(sdin)});

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(addr) != CODE_CFG) |-> $stable(cfg_word));

   // R9
   wsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(addr) != CODE_WSR) |-> $stable(wsr_word));
endmodule

bind cell_ring_bank cell_ring_bank_chk #(
   .CELLS(CELLS), .CFG_W(CFG_W), .WSR_W(WSR_W), .ADDR_W(ADDR_W),
   .CODE_RING(CODE_RING), .CODE_CFG(CODE_CFG), .CODE_WSR(CODE_WSR),
   .PRIO_ENC(PRIO_ENC)
) u_chk (.*);

// File: tb/sim_cell_ring_bank.sv
`timescale 1ns/1ps
module sim_cell_ring_bank;
   localparam int N = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = 4'h0;
   logic       sdin = 1'b0;
   logic       ring_tail;
   logic [9:0] cell_idx;
   logic       cell_hit;
   logic [7:0] cfg_word;
   logic [7:0] wsr_word;

   always #5 clk = ~clk;

   cell_ring_bank u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sdin(sdin),
      .ring_tail(ring_tail), .cell_idx(cell_idx), .cell_hit(cell_hit),
      .cfg_word(cfg_word), .wsr_word(wsr_word)
   );

   typedef struct {
      int       idx;
      bit       chk_idx;
      bit       tail;
      bit       chk_tail;
      logic [7:0] cfg;
      logic [7:0] wsr;
      string    req;
   } exp_t;

   exp_t q[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   int m_pos = -1;
   int zrun = 0;
   logic [7:0] m_cfg = 8'hFF;
   logic [7:0] m_wsr = 8'hFF;

   task automatic step(input logic [3:0] a, input logic d, input logic r, input string req);
      exp_t it;
      @(negedge clk);
      addr = a; sdin = d; rst_n = r;
      it.chk_idx = 0; it.chk_tail = 0; it.idx = 0; it.tail = 0; it.req = req;
      if (!r) begin m_cfg = 8'hFF; m_wsr = 8'hFF; end
      else if (a == 4'hC) m_cfg = {m_cfg[6:0], d};
      else if (a == 4'hD) m_wsr = {m_wsr[6:0], d};
      if (a == 4'hB) begin
         if (m_pos >= 0) m_pos = (m_pos == N-2) ? -1 : ((m_pos == N-1) ? 0 : m_pos + 1);
         if (d) begin
            m_pos = (zrun >= N-1) ? N-1 : -1;
            zrun = 0;
         end else zrun++;
         it.tail = d; it.chk_tail = 1;
         if (m_pos >= 0) begin it.chk_idx = 1; it.idx = m_pos; end
      end else begin
         zrun = 0;
         if (m_pos >= 0) begin
            m_pos = (m_pos + 1) % N;
            it.chk_idx = 1; it.idx = m_pos;
            it.chk_tail = 1; it.tail = (m_pos == N-1);
         end
      end
      it.cfg = m_cfg; it.wsr = m_wsr;
      q.push_back(it);
   endtask

   task automatic load_ring(input string req);
      for (int i = 0; i < N-1; i++) step(4'hB, 1'b0, 1'b1, "R2");
      step(4'hB, 1'b1, 1'b1, req);
   endtask

   task automatic load_byte(input logic [3:0] a, input logic [7:0] v, input string req);
      for (int b = 7; b >= 0; b--) step(a, v[b], 1'b1, req);
   endtask

   // monitor
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_cmp++;
         if (cfg_word !== e.cfg) begin
            n_bad++; $display("FAIL %s cfg_word got %h exp %h", e.req, cfg_word, e.cfg);
         end
         n_cmp++;
         if (wsr_word !== e.wsr) begin
            n_bad++; $display("FAIL %s wsr_word got %h exp %h", e.req, wsr_word, e.wsr);
         end
         if (e.chk_tail) begin
            n_cmp++;
            if (ring_tail !== e.tail) begin
               n_bad++; $display("FAIL %s ring_tail got %b exp %b", e.req, ring_tail, e.tail);
            end
         end
         if (e.chk_idx) begin
            n_cmp++;
            if (cell_idx !== 10'(e.idx) || cell_hit !== 1'b1) begin
               n_bad++;
               $display("FAIL %s cell_idx/hit got %0d/%b exp %0d/1", e.req, cell_idx, cell_hit, e.idx);
            end
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired got running exp finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state of the two words
      step(4'h0, 1'b0, 1'b0, "R1");
      step(4'h0, 1'b0, 1'b0, "R1");
      // R3: first initialization of the ring
      load_ring("R3");
      // R4: recirculation including wrap and full return
      for (int i = 0; i < N + 6; i++) step(4'h0, 1'b0, 1'b1, "R4");
      // R7 / R8: MSB-first word loads
      load_byte(4'hC, 8'hA5, "R7");
      load_byte(4'hD, 8'h3C, "R8");
      // R9: other codes leave the words alone, ring keeps rotating
      step(4'h1, 1'b1, 1'b1, "R9");
      step(4'h5, 1'b0, 1'b1, "R9");
      step(4'hA, 1'b1, 1'b1, "R9");
      step(4'hE, 1'b1, 1'b1, "R9");
      step(4'hF, 1'b1, 1'b1, "R9");
      // R6: reset held, ring keeps advancing, words return to ones
      step(4'h0, 1'b1, 1'b0, "R6");
      step(4'h0, 1'b1, 1'b0, "R6");
      step(4'h0, 1'b0, 1'b0, "R6");
      step(4'h0, 1'b0, 1'b1, "R6");
      // R3: re-initialization from an arbitrary marker position
      for (int i = 0; i < 300; i++) step(4'h0, 1'b0, 1'b1, "R4");
      load_ring("R3");
      // R5: position reporting around the tail
      for (int i = 0; i < 4; i++) step(4'h0, 1'b0, 1'b1, "R5");
      for (int i = 0; i < N - 5; i++) step(4'h0, 1'b0, 1'b1, "R4");
      step(4'h0, 1'b0, 1'b1, "R5");
      step(4'h0, 1'b0, 1'b1, "R5");
      wait (q.size() == 0);
      @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule